// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This controller sits next to a small processor core and handles the switch into and out of interrupt and fault handlers. External request lines are held off until the core reports that an instruction has retired. A fault raised by the running instruction is taken at once, and the core is told to abandon that instruction. On entry the block pushes the return program counter and the status word onto an internal eight-entry context stack. It then reads the handler address from a vector table and hands that address to the core together with a status word that has global interrupts disabled.

When the core reports that a return-from-interrupt instruction has retired, the most recent context is popped and sent back to the core, which resumes the interrupted code. Nested entries each take one stack slot. An entry attempted with the stack full sets a sticky overflow flag and is not taken. A return attempted with the stack empty sets a sticky underflow flag.

The vector table read is a request stream. `vt_req_valid` stays high with `vt_addr` unchanged until the cycle in which `vt_req_ready` is high, so the memory may apply back-pressure for any number of cycles. The response is accepted in any cycle of the load step in which `vt_rsp_valid` is high, so a slow memory simply lengthens that step. With no back-pressure, entry takes three cycles: save, issue, load.

Top module: `intr_sequencer`

## Requirements
- R1: After reset, `busy`, `irq_ack`, `abort_instr`, `vt_req_valid`, `pc_load`, `ovf_flag` and `unf_flag` are all 0, and the context stack is empty.
- R2: An external request is taken only in a cycle where `instr_done` is 1 and status bit 7 (global enable) of `core_sr` is 1. Otherwise it is ignored, and `irq_ack` and `busy` stay 0.
- R3: `fault_req` is taken even without `instr_done` and even with bit 7 clear. It wins over any external request. `abort_instr` pulses for one cycle in the save step, and the saved return PC is `cur_pc`.
- R4: Among external requests, the lowest index wins. `irq_ack` is one-hot for the winner and high only in the save step, which is the cycle after the decision.
- R5: Vector number: the fault uses NUM_SRC (4). External source 3 supplies its own vector on `periph_vec`, sampled in the save step. Sources 0 to 2 use their index. The vector address is 0x0100 + 4 × vector number.
- R6: Entry runs save, issue and load in order. `vt_req_valid` is high in the issue step and holds with a stable `vt_addr` until `vt_req_ready` is 1. The load step waits for `vt_rsp_valid`.
- R7: In the entry load cycle, `pc_load` is 1, `pc_val` equals `vt_rsp_data`, and `sr_val` is the saved status with bit 7 cleared. For an external entry the saved return PC is `next_pc`.
- R8: When `rti` is 1 in an idle cycle and the stack is not empty, the next cycle shows `pc_load`=1 with the most recently saved PC and the full saved status, in last-in first-out order.
- R9: An entry attempted while eight contexts are held is not taken: there is no acknowledge, `busy` stays 0, and `ovf_flag` becomes 1 and stays 1.
- R10: An `rti` with an empty stack produces no `pc_load`, and `unf_flag` becomes 1 and stays 1.
- R11: `busy` is 1 from the save step until the cycle after the final load or restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_SRC | External request levels |
| irq_ack | output | NUM_SRC | One-cycle acknowledge to the serviced source |
| periph_vec | input | VEC_W | Vector number from a source that supplies its own |
| fault_req | input | 1 | Fault raised by the executing instruction |
| abort_instr | output | 1 | Pulse telling the core to abandon the current instruction |
| instr_done | input | 1 | The current instruction retires this cycle |
| rti | input | 1 | A return-from-interrupt instruction retires this cycle |
| cur_pc | input | PC_W | PC of the instruction in progress |
| next_pc | input | PC_W | PC of the following instruction |
| core_sr | input | SR_W | Current status word |
| busy | output | 1 | Sequence in progress; the core holds |
| vt_req_valid | output | 1 | Vector table read request valid |
| vt_req_ready | input | 1 | Vector table accepts the request |
| vt_addr | output | ADDR_W | Vector table entry address |
| vt_rsp_valid | input | 1 | Vector table data valid |
| vt_rsp_data | input | PC_W | Handler address read from the table |
| pc_load | output | 1 | The core loads `pc_val` and `sr_val` |
| pc_val | output | PC_W | PC to load |
| sr_val | output | SR_W | Status word to load |
| ovf_flag | output | 1 | Sticky context stack overflow |
| unf_flag | output | 1 | Sticky context stack underflow |

## Verification
Entry is exercised with single requests, with several requests pending at once, with a fault together with an external request, and with a source that supplies its own vector. Together these separate the priority order, fault precedence, and the choice between a preassigned and a supplied vector number. Requests arriving without an instruction boundary or with the global enable clear must leave no trace, while a fault under the same conditions is still taken. Eight nested entries followed by a ninth, then eight returns followed by a ninth, show last-in first-out restore order and both sticky flags. Stalling the table request and its response shows that the address holds and the load waits.

// File: rtl/intr_pkg.sv
`timescale 1ns/1ps
package intr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAVE  = 3'd1,
    ST_ISSUE = 3'd2,
    ST_LOAD  = 3'd3,
    ST_RET   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/prio_pick.sv
`timescale 1ns/1ps
module prio_pick #(
  parameter int NUM   = 4,
  parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0]   req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [NUM:0]   seen;
  logic [NUM-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[NUM];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ctx_stack.sv
`timescale 1ns/1ps
module ctx_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;

  assign cnt_m1 = cnt - CW'(1);
  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign top    = mem[cnt_m1[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + CW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[AW-1:0]] <= din;
  end
endmodule

// File: rtl/vec_addr_calc.sv
`timescale 1ns/1ps
module vec_addr_calc #(
  parameter int                NUM_SRC     = 4,
  parameter int                IDX_W       = 2,
  parameter int                VEC_W       = 8,
  parameter int                ADDR_W      = 16,
  parameter int unsigned       VT_BASE     = 32'h100,
  parameter logic [NUM_SRC-1:0] PERIPH_MASK = '0
) (
  input  logic              is_fault,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [VEC_W-1:0]  periph_vec,
  output logic [ADDR_W-1:0] vaddr
);
  logic [VEC_W-1:0] vec_num;

  always_comb begin
    if (is_fault)                  vec_num = VEC_W'(NUM_SRC);
    else if (PERIPH_MASK[src_idx]) vec_num = periph_vec;
    else                           vec_num = VEC_W'(src_idx);
  end

  assign vaddr = ADDR_W'(VT_BASE) + (ADDR_W'(vec_num) << 2);
endmodule

// File: rtl/intr_sequencer.sv
`timescale 1ns/1ps
module intr_sequencer
  import intr_pkg::*;
#(
  parameter int                 NUM_SRC     = 4,
  parameter int                 DEPTH       = 8,
  parameter int                 PC_W        = 16,
  parameter int                 SR_W        = 8,
  parameter int                 VEC_W       = 8,
  parameter int                 ADDR_W      = 16,
  parameter int                 IE_BIT      = 7,
  parameter int unsigned        VT_BASE     = 32'h100,
  parameter logic [NUM_SRC-1:0] PERIPH_MASK = 4'b1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic [NUM_SRC-1:0] irq_ack,
  input  logic [VEC_W-1:0]   periph_vec,
  input  logic               fault_req,
  output logic               abort_instr,
  input  logic               instr_done,
  input  logic               rti,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic [PC_W-1:0]    next_pc,
  input  logic [SR_W-1:0]    core_sr,
  output logic               busy,
  output logic               vt_req_valid,
  input  logic               vt_req_ready,
  output logic [ADDR_W-1:0]  vt_addr,
  input  logic               vt_rsp_valid,
  input  logic [PC_W-1:0]    vt_rsp_data,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_val,
  output logic [SR_W-1:0]    sr_val,
  output logic               ovf_flag,
  output logic               unf_flag
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CTX_W = PC_W + SR_W;
  localparam logic [SR_W-1:0] IE_MASK = SR_W'(1) << IE_BIT;

  seq_state_e        state_q, state_d;
  logic              fault_q, fault_d;
  logic [IDX_W-1:0]  src_q, src_d;
  logic [PC_W-1:0]   rpc_q, rpc_d;
  logic [SR_W-1:0]   rsr_q, rsr_d;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;
  logic              ovf_q, ovf_d;
  logic              unf_q, unf_d;

  logic              ext_any;
  logic [IDX_W-1:0]  ext_idx;
  logic [ADDR_W-1:0] calc_addr;
  logic              stk_push, stk_pop, stk_full, stk_empty;
  logic [CTX_W-1:0]  stk_top;
  logic              ext_take;

  prio_pick #(.NUM(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req (irq_req),
    .any (ext_any),
    .idx (ext_idx)
  );

  vec_addr_calc #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
    .VT_BASE(VT_BASE), .PERIPH_MASK(PERIPH_MASK)
  ) u_vec (
    .is_fault   (fault_q),
    .src_idx    (src_q),
    .periph_vec (periph_vec),
    .vaddr      (calc_addr)
  );

  ctx_stack #(.DEPTH(DEPTH), .W(CTX_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (stk_push),
    .pop   (stk_pop),
    .din   ({rpc_q, rsr_q}),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  assign ext_take = instr_done && core_sr[IE_BIT] && ext_any;
  assign stk_push = (state_q == ST_SAVE);
  assign stk_pop  = (state_q == ST_RET);

  // next-state and capture logic
  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    src_d   = src_q;
    rpc_d   = rpc_q;
    rsr_d   = rsr_q;
    vaddr_d = vaddr_q;
    ovf_d   = ovf_q;
    unf_d   = unf_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fault_req) begin
          if (stk_full) begin
            ovf_d = 1'b1;
          end else begin
            state_d = ST_SAVE;
            fault_d = 1'b1;
            src_d   = '0;
            rpc_d   = cur_pc;
            rsr_d   = core_sr;
          end
        end else if (rti) begin
          if (stk_empty) unf_d = 1'b1;
          else           state_d = ST_RET;
        end else if (ext_take) begin
          if (stk_full) begin
            ovf_d = 1'b1;
          end else begin
            state_d = ST_SAVE;
            fault_d = 1'b0;
            src_d   = ext_idx;
            rpc_d   = next_pc;
            rsr_d   = core_sr;
          end
        end
      end
      ST_SAVE: begin
        vaddr_d = calc_addr;
        state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (vt_req_ready) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (vt_rsp_valid) state_d = ST_IDLE;
      end
      ST_RET: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
      src_q   <= '0;
      rpc_q   <= '0;
      rsr_q   <= '0;
      vaddr_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      src_q   <= src_d;
      rpc_q   <= rpc_d;
      rsr_q   <= rsr_d;
      vaddr_q <= vaddr_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  // acknowledge decode
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign irq_ack[i] = (state_q == ST_SAVE) && !fault_q && (src_q == IDX_W'(i));
  end

  assign abort_instr  = (state_q == ST_SAVE) && fault_q;
  assign busy         = (state_q != ST_IDLE);
  assign vt_req_valid = (state_q == ST_ISSUE);
  assign vt_addr      = vaddr_q;
  assign ovf_flag     = ovf_q;
  assign unf_flag     = unf_q;

  always_comb begin
    pc_load = 1'b0;
    pc_val  = '0;
    sr_val  = '0;
    if (state_q == ST_LOAD && vt_rsp_valid) begin
      pc_load = 1'b1;
      pc_val  = vt_rsp_data;
      sr_val  = rsr_q & ~IE_MASK;
    end else if (state_q == ST_RET) begin
      pc_load = 1'b1;
      pc_val  = stk_top[CTX_W-1:SR_W];
      sr_val  = stk_top[SR_W-1:0];
    end
  end
endmodule

// File: rtl/intr_seq_checker.sv
`timescale 1ns/1ps
module intr_seq_checker #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 16,
  parameter int SR_W    = 8,
  parameter int IE_BIT  = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_ack,
  input logic               abort_instr,
  input logic               instr_done,
  input logic [SR_W-1:0]    core_sr,
  input logic               vt_req_valid,
  input logic               vt_req_ready,
  input logic [ADDR_W-1:0]  vt_addr,
  input logic               ovf_flag,
  input logic               unf_flag
);
  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, abort_instr}));

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> !(|irq_ack));

  p_ack_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> ($past(instr_done) && $past(core_sr[IE_BIT])));

  p_save_then_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_ack) || abort_instr) |=> vt_req_valid);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vt_req_valid && !vt_req_ready) |=> (vt_req_valid && $stable(vt_addr)));

  p_addr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vt_req_valid |-> (vt_addr[1:0] == 2'b00));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);
endmodule

bind intr_sequencer intr_seq_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SR_W(SR_W), .IE_BIT(IE_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_ack      (irq_ack),
  .abort_instr  (abort_instr),
  .instr_done   (instr_done),
  .core_sr      (core_sr),
  .vt_req_valid (vt_req_valid),
  .vt_req_ready (vt_req_ready),
  .vt_addr      (vt_addr),
  .ovf_flag     (ovf_flag),
  .unf_flag     (unf_flag)
);

// File: tb/tb_intr_sequencer.sv
`timescale 1ns/1ps
module tb_intr_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_req = '0;
  logic [3:0]  irq_ack;
  logic [7:0]  periph_vec = '0;
  logic        fault_req = 1'b0;
  logic        abort_instr;
  logic        instr_done = 1'b0;
  logic        rti = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [15:0] next_pc = '0;
  logic [7:0]  core_sr = '0;
  logic        busy;
  logic        vt_req_valid;
  logic        vt_req_ready = 1'b1;
  logic [15:0] vt_addr;
  logic        vt_rsp_valid;
  logic        rsp_en = 1'b1;
  logic [15:0] vt_rsp_data;
  logic        pc_load;
  logic [15:0] pc_val;
  logic [7:0]  sr_val;
  logic        ovf_flag, unf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // table memory model: handler address derived from the entry address
  assign vt_rsp_valid = rsp_en;
  assign vt_rsp_data  = vt_addr ^ 16'h8000;

  intr_sequencer dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .periph_vec(periph_vec), .fault_req(fault_req), .abort_instr(abort_instr),
    .instr_done(instr_done), .rti(rti), .cur_pc(cur_pc), .next_pc(next_pc),
    .core_sr(core_sr), .busy(busy), .vt_req_valid(vt_req_valid),
    .vt_req_ready(vt_req_ready), .vt_addr(vt_addr), .vt_rsp_valid(vt_rsp_valid),
    .vt_rsp_data(vt_rsp_data), .pc_load(pc_load), .pc_val(pc_val),
    .sr_val(sr_val), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_inputs();
    irq_req = '0; fault_req = 1'b0; instr_done = 1'b0; rti = 1'b0;
  endtask

  // full entry; called just after a negedge
  task automatic run_entry(input logic [3:0] irq, input logic flt, input logic bnd,
                           input logic [7:0] sr, input logic [15:0] cpc,
                           input logic [15:0] npc, input logic [7:0] pvec,
                           input logic [3:0] exp_ack, input logic [7:0] exp_vec);
    logic [15:0] exp_addr;
    exp_addr = 16'h0100 + {exp_vec, 2'b00};
    irq_req = irq; fault_req = flt; instr_done = bnd; core_sr = sr;
    cur_pc = cpc; next_pc = npc; periph_vec = pvec;
    @(negedge clk);
    chk("R4 ack in save step", irq_ack, exp_ack);
    chk("R3 abort pulse", abort_instr, flt);
    chk("R11 busy in save", busy, 1'b1);
    clr_inputs();
    @(negedge clk);
    chk("R6 request valid in issue", vt_req_valid, 1'b1);
    chk("R5 vector address", vt_addr, exp_addr);
    @(negedge clk);
    chk("R7 pc_load on entry", pc_load, 1'b1);
    chk("R7 handler pc", pc_val, exp_addr ^ 16'h8000);
    chk("R7 status masked", sr_val, sr & 8'h7F);
    @(negedge clk);
    chk("R11 busy cleared", busy, 1'b0);
  endtask

  task automatic run_return(input logic [15:0] exp_pc, input logic [7:0] exp_sr);
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    chk("R8 restore load", pc_load, 1'b1);
    chk("R8 restored pc", pc_val, exp_pc);
    chk("R8 restored status", sr_val, exp_sr);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0] irq;
    logic       flt;
    logic [7:0] pvec;
    logic [3:0] ack;
    logic [7:0] vec;
  } vrow_t;

  localparam vrow_t TBL [6] = '{
    '{4'b0001, 1'b0, 8'h00, 4'b0001, 8'd0},   // single low source (R4, R5)
    '{4'b0110, 1'b0, 8'h00, 4'b0010, 8'd1},   // two pending, lowest wins (R4)
    '{4'b1000, 1'b0, 8'h2A, 4'b1000, 8'h2A},  // supplied vector (R5)
    '{4'b1100, 1'b0, 8'h33, 4'b0100, 8'd2},   // preassigned beats supplied (R4)
    '{4'b0001, 1'b1, 8'h00, 4'b0000, 8'd4},   // fault over external (R3)
    '{4'b1000, 1'b0, 8'h07, 4'b1000, 8'h07}   // supplied vector again (R5)
  };

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 ack", irq_ack, 4'b0);
    chk("R1 request", vt_req_valid, 1'b0);
    chk("R1 load", pc_load, 1'b0);
    chk("R1 flags", {ovf_flag, unf_flag}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: entry then return each time
    for (int i = 0; i < 6; i++) begin
      logic [15:0] cpc, npc;
      logic [7:0] sr;
      cpc = 16'h2000 + 16'(i * 8);
      npc = cpc + 16'd2;
      sr  = 8'h80 | 8'(i);
      run_entry(TBL[i].irq, TBL[i].flt, 1'b1, sr, cpc, npc, TBL[i].pvec,
                TBL[i].ack, TBL[i].vec);
      run_return(TBL[i].flt ? cpc : npc, sr);
    end

    // R2: no boundary -> ignored
    irq_req = 4'b0001; instr_done = 1'b0; core_sr = 8'h80;
    @(negedge clk);
    chk("R2 no boundary ack", irq_ack, 4'b0);
    chk("R2 no boundary busy", busy, 1'b0);
    // R2: enable bit clear -> ignored
    instr_done = 1'b1; core_sr = 8'h00;
    @(negedge clk);
    chk("R2 masked ack", irq_ack, 4'b0);
    chk("R2 masked busy", busy, 1'b0);
    clr_inputs();
    // R3: fault taken with no boundary and enable clear
    run_entry(4'b0000, 1'b1, 1'b0, 8'h05, 16'h3000, 16'h3004, 8'h00, 4'b0000, 8'd4);
    run_return(16'h3000, 8'h05);

    // R6: back-pressure on request and response
    irq_req = 4'b0010; instr_done = 1'b1; core_sr = 8'h81; next_pc = 16'h4444;
    vt_req_ready = 1'b0; rsp_en = 1'b0;
    @(negedge clk);
    clr_inputs();
    repeat (3) @(negedge clk);
    chk("R6 request held", vt_req_valid, 1'b1);
    chk("R6 address held", vt_addr, 16'h0104);
    vt_req_ready = 1'b1;
    @(negedge clk);
    chk("R6 load waits for data", pc_load, 1'b0);
    chk("R6 still busy", busy, 1'b1);
    rsp_en = 1'b1;
    #1;
    chk("R6 load with data", pc_load, 1'b1);
    chk("R7 handler after stall", pc_val, 16'h8104);
    @(negedge clk);
    run_return(16'h4444, 8'h81);

    // R9: fill eight levels then overflow
    for (int k = 0; k < 8; k++) begin
      run_entry(4'b0001, 1'b0, 1'b1, 8'h80 | 8'(k), 16'h1000, 16'h1100 + 16'(k),
                8'h00, 4'b0001, 8'd0);
    end
    chk("R9 no overflow yet", ovf_flag, 1'b0);
    irq_req = 4'b0001; instr_done = 1'b1; core_sr = 8'h80;
    @(negedge clk);
    clr_inputs();
    chk("R9 no ack when full", irq_ack, 4'b0);
    chk("R9 not busy when full", busy, 1'b0);
    chk("R9 overflow set", ovf_flag, 1'b1);
    @(negedge clk);
    chk("R9 overflow sticky", ovf_flag, 1'b1);
    // R8: returns in reverse order
    for (int k = 7; k >= 0; k--) begin
      run_return(16'h1100 + 16'(k), 8'h80 | 8'(k));
    end
    // R10: return with empty stack
    chk("R10 no underflow yet", unf_flag, 1'b0);
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    chk("R10 no load on empty", pc_load, 1'b0);
    chk("R10 underflow set", unf_flag, 1'b1);
    @(negedge clk);
    chk("R10 underflow sticky", unf_flag, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule